// File: doc/BRIEF.md
# Converter Bus Control and Result Steering

This block sits between a processor bus and a successive-approximation converter core. It decodes each bus cycle from an enable, an active-low select, a read/convert line, an address bit and a static width strap. When the decoded cycle asks for a conversion, the block sends a one-cycle start pulse and a latched length select to the core. It then keeps a busy flag raised until the core signals completion, and stores the core's result when that happens.

A read cycle places the stored 12-bit result on a 12-line data bus. An output-enable vector marks which lines are driven; every other line is high impedance. With the strap high the whole word appears at once. With the strap low the result is delivered as two left-justified bytes on the upper eight lines. While busy, the block refuses both reads and new starts.

The same logic also covers a stand-alone setup. Enable and strap are tied high, select and address are tied low, and pulses on the read/convert line alone control the converter.

Top module: `adc_bus_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, start, short-select and busy are 0, and no data line is enabled.
- R2: The cycle is selected only when ce_i=1 and cs_n_i=0. If the selected cycle has rc_i=0 and was not selected-with-rc_i=0 at the previous clock edge, and busy is low, then core_start_o is 1 for exactly the next cycle and busy_o is 1 from that same cycle.
- R3: Holding the convert condition active over many edges produces only one start pulse.
- R4: core_short_o takes the value of a0_i at the accepting edge (1 = short 8-bit cycle, 0 = full 12-bit cycle) and stays unchanged while busy.
- R5: busy_o returns to 0 one cycle after core_done_i is seen high while busy, and the result register takes core_result_i on that edge.
- R6: While busy, new convert edges give no start pulse. This includes an edge that falls on the same cycle as core_done_i, and such an edge is consumed.
- R7: While busy, data_oe_o is all zero, even during a read cycle.
- R8: A selected read (rc_i=1) with word_mode_i=1 and not busy gives data_oe_o=12'hFFF and data_o equal to the stored result, in the same cycle.
- R9: A selected read with word_mode_i=0 and a0_i=0 gives data_oe_o=12'hFF0 and data_o[11:4]=result[11:4], with data_o[3:0]=0.
- R10: A selected read with word_mode_i=0 and a0_i=1 gives data_oe_o=12'hFF0 and data_o[11:4]={result[3:0],4'b0000}.
- R11: When ce_i=0 or cs_n_i=1, no start occurs and no data line is enabled, whatever rc_i is.
- R12: In stand-alone use (ce_i=1, cs_n_i=0, a0_i=0, word_mode_i=1), a falling rc_i turns the outputs off in the same cycle. They come back holding the new result once busy clears with rc_i already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Bus enable, active high |
| cs_n_i | input | 1 | Bus select, active low |
| rc_i | input | 1 | 1 = read, 0 = convert |
| a0_i | input | 1 | Length select at start, byte select at read |
| word_mode_i | input | 1 | Width strap: 1 = 12-bit word, 0 = two bytes |
| core_done_i | input | 1 | Conversion complete from core |
| core_result_i | input | 12 | Result code from core |
| core_start_o | output | 1 | One-cycle start pulse to core |
| core_short_o | output | 1 | Latched length select, 1 = short cycle |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 12 | Data bus value |
| data_oe_o | output | 12 | Per-line drive enable, 0 = high impedance |

## Verification
Two functions can fall in the same cycle: the core's completion and a fresh convert edge on the bus. The bench provokes this by raising core_done_i on the same cycle that it first drives a selected convert cycle. It then expects busy to drop with no start pulse, and it expects no start later while the command is still held, because the edge has been used up. A second overlap, a read attempted while busy, is driven on every busy cycle of the random runs. It is judged by an all-zero enable vector.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = RES_W - BYTE_W;
    localparam int PAD_W  = BYTE_W - NIB_W;

    typedef logic [RES_W-1:0] word_t;

    typedef struct packed {
        logic read;
        logic conv;
    } bus_cmd_t;

    typedef struct packed {
        word_t data;
        word_t oe;
    } drive_t;

    function automatic bus_cmd_t decode_cmd(input logic ce, input logic cs_n, input logic rc);
        bus_cmd_t c;
        c.read = ce & ~cs_n & rc;
        c.conv = ce & ~cs_n & ~rc;
        return c;
    endfunction

    function automatic drive_t steer(input word_t res, input logic word_mode, input logic a0);
        drive_t d;
        d = '0;
        if (word_mode) begin
            d.data = res;
            d.oe   = '1;
        end else begin
            d.oe[RES_W-1 -: BYTE_W] = '1;
            if (!a0)
                d.data[RES_W-1 -: BYTE_W] = res[RES_W-1 -: BYTE_W];
            else
                d.data[RES_W-1 -: BYTE_W] = {res[NIB_W-1:0], {PAD_W{1'b0}}};
        end
        return d;
    endfunction
endpackage

// File: rtl/cnv_start_ctl.sv
module cnv_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic conv_req_i,
    input  logic a0_i,
    input  logic core_done_i,
    output logic start_o,
    output logic busy_o,
    output logic short_o,
    output logic take_o
);
    logic req_q;
    logic edge_ok;

    assign edge_ok = conv_req_i & ~req_q & ~busy_o;
    assign take_o  = busy_o & core_done_i & ~start_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            start_o <= 1'b0;
            busy_o  <= 1'b0;
            short_o <= 1'b0;
        end else begin
            req_q   <= conv_req_i;
            start_o <= 1'b0;
            if (edge_ok) begin
                start_o <= 1'b1;
                busy_o  <= 1'b1;
                short_o <= a0_i;
            end else if (take_o) begin
                busy_o  <= 1'b0;
            end
        end
    end

    a_r2_start_implies_busy: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);
    a_r6_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !start_o);
    a_r4_length_stable: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start_o) |=> (busy_o ? $stable(short_o) : 1'b1));
    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
        (busy_o && core_done_i && !start_o) |=> !busy_o);
endmodule

// File: rtl/result_hold.sv
module result_hold
    import adc_bus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_i,
    input  word_t res_i,
    output word_t res_o
);
    always_ff @(posedge clk) begin
        if (rst)
            res_o <= '0;
        else if (take_i)
            res_o <= res_i;
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (res_o == $past(res_i)));
endmodule

// File: rtl/bus_steer.sv
module bus_steer
    import adc_bus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  read_i,
    input  logic  busy_i,
    input  logic  word_mode_i,
    input  logic  a0_i,
    input  word_t res_i,
    output word_t data_o,
    output word_t oe_o
);
    drive_t drv;

    always_comb begin
        drv = '0;
        if (read_i && !busy_i)
            drv = steer(res_i, word_mode_i, a0_i);
    end

    assign data_o = drv.data;
    assign oe_o   = drv.oe;

    a_r7_off_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (oe_o == '0));
    a_r11_off_when_unselected: assert property (@(posedge clk) disable iff (rst)
        !read_i |-> (oe_o == '0));
    a_r9_lower_nibble_idle: assert property (@(posedge clk) disable iff (rst)
        !word_mode_i |-> (oe_o[NIB_W-1:0] == '0 && data_o[NIB_W-1:0] == '0));
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic              cs_n_i,
    input  logic              rc_i,
    input  logic              a0_i,
    input  logic              word_mode_i,
    input  logic              core_done_i,
    input  logic [RES_W-1:0]  core_result_i,
    output logic              core_start_o,
    output logic              core_short_o,
    output logic              busy_o,
    output logic [RES_W-1:0]  data_o,
    output logic [RES_W-1:0]  data_oe_o
);
    bus_cmd_t cmd;
    logic     take;
    word_t    res_q;

    assign cmd = decode_cmd(ce_i, cs_n_i, rc_i);

    cnv_start_ctl u_start (
        .clk         (clk),
        .rst         (rst),
        .conv_req_i  (cmd.conv),
        .a0_i        (a0_i),
        .core_done_i (core_done_i),
        .start_o     (core_start_o),
        .busy_o      (busy_o),
        .short_o     (core_short_o),
        .take_o      (take)
    );

    result_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .take_i (take),
        .res_i  (core_result_i),
        .res_o  (res_q)
    );

    bus_steer u_steer (
        .clk         (clk),
        .rst         (rst),
        .read_i      (cmd.read),
        .busy_i      (busy_o),
        .word_mode_i (word_mode_i),
        .a0_i        (a0_i),
        .res_i       (res_q),
        .data_o      (data_o),
        .oe_o        (data_oe_o)
    );

    a_r11_no_start_unselected: assert property (@(posedge clk) disable iff (rst)
        (!ce_i || cs_n_i) |=> !core_start_o);
endmodule

// File: tb/tb_adc_bus_ctrl.sv
module tb_adc_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        ce, cs_n, rc, a0, word_mode, done;
    logic [11:0] result;
    logic        start, short_sel, busy;
    logic [11:0] data, oe;

    int checks = 0;
    int bad    = 0;
    logic [11:0] exp_res = 12'h000;

    always #2 clk = ~clk;

    adc_bus_ctrl dut (
        .clk(clk), .rst(rst), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc), .a0_i(a0),
        .word_mode_i(word_mode), .core_done_i(done), .core_result_i(result),
        .core_start_o(start), .core_short_o(short_sel), .busy_o(busy),
        .data_o(data), .data_oe_o(oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [23:0] model(input logic [11:0] r, input logic w, input logic a);
        if (w)       return {12'hFFF, r};
        else if (!a) return {12'hFF0, r[11:4], 4'h0};
        else         return {12'hFF0, r[3:0], 8'h00};
    endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic idle();
        ce = 1'b0; cs_n = 1'b1; rc = 1'b1;
    endtask

    task automatic do_read(input logic w, input logic a, input string req);
        ce = 1'b1; cs_n = 1'b0; rc = 1'b1; word_mode = w; a0 = a;
        #1;
        chk({oe, data} == model(exp_res, w, a), req, {8'h0, oe, data}, {8'h0, model(exp_res, w, a)});
    endtask

    task automatic convert(input logic av, input logic [11:0] r, input int lat);
        idle();
        tick();
        ce = 1'b1; cs_n = 1'b0; rc = 1'b0; a0 = av;
        #1 chk(oe == 12'h000, "R7 convert cycle drives nothing", oe, 0);
        tick(); #1;
        chk(start == 1'b1, "R2 start pulse", start, 1);
        chk(busy == 1'b1, "R2 busy set", busy, 1);
        chk(short_sel == av, "R4 length latched", short_sel, av);
        for (int i = 0; i < lat; i++) begin
            tick();
            rc = $urandom_range(0, 1); a0 = $urandom_range(0, 1);
            word_mode = $urandom_range(0, 1);
            #1 chk(oe == 12'h000, "R7 no drive while busy", oe, 0);
            chk(start == 1'b0, "R3/R6 no extra start", start, 0);
            chk(short_sel == av, "R4 length stable", short_sel, av);
        end
        tick();
        idle(); done = 1'b1; result = r;
        tick();
        done = 1'b0; result = $urandom;
        #1 chk(busy == 1'b0, "R5 busy cleared", busy, 0);
        chk(start == 1'b0, "R6 no start at completion", start, 0);
        exp_res = r;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; idle(); a0 = 1'b0; word_mode = 1'b1; done = 1'b0; result = 12'h000;
        repeat (3) tick();
        #1 chk(busy == 1'b0 && start == 1'b0 && oe == 12'h000, "R1 in reset", {busy, start, oe}, 0);
        rst = 1'b0;
        tick();
        #1 chk(busy == 1'b0 && start == 1'b0 && short_sel == 1'b0, "R1 after reset", {busy, start, short_sel}, 0);
        chk(oe == 12'h000, "R1 no drive after reset", oe, 0);

        // R11: unselected cycles do nothing
        ce = 1'b0; cs_n = 1'b0; rc = 1'b0;
        #1 chk(oe == 12'h000, "R11 ce low", oe, 0);
        tick(); #1 chk(start == 1'b0, "R11 ce low no start", start, 0);
        ce = 1'b1; cs_n = 1'b1; rc = 1'b0;
        tick(); #1 chk(start == 1'b0 && busy == 1'b0, "R11 cs high no start", {start, busy}, 0);
        rc = 1'b1;
        #1 chk(oe == 12'h000, "R11 cs high no read", oe, 0);

        // directed full conversion and all read formats
        convert(1'b0, 12'hA5C, 5);
        do_read(1'b1, 1'b0, "R8 word read");
        do_read(1'b0, 1'b0, "R9 high byte");
        do_read(1'b0, 1'b1, "R10 low nibble byte");
        convert(1'b1, 12'h3F7, 3);
        do_read(1'b0, 1'b1, "R10 low nibble byte 2");
        do_read(1'b1, 1'b1, "R8 word read a0 high");

        // R3: held convert produces one pulse only
        idle(); tick();
        ce = 1'b1; cs_n = 1'b0; rc = 1'b0; a0 = 1'b0;
        tick(); #1 chk(start == 1'b1, "R2 held start", start, 1);
        for (int i = 0; i < 3; i++) begin
            tick(); #1 chk(start == 1'b0, "R3 held no repeat", start, 0);
        end
        done = 1'b1; result = 12'h0F0;
        tick(); done = 1'b0; exp_res = 12'h0F0;
        #1 chk(busy == 1'b0, "R5 clear while held", busy, 0);
        tick(); #1 chk(start == 1'b0, "R3 still held after done", start, 0);

        // R6: done and fresh convert edge in the same cycle
        convert(1'b0, 12'h111, 2);
        idle(); tick();
        ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
        tick(); #1 chk(start == 1'b1, "R2 start before collision", start, 1);
        idle();
        tick(); tick();
        ce = 1'b1; cs_n = 1'b0; rc = 1'b0; done = 1'b1; result = 12'hC3A;
        tick(); done = 1'b0; exp_res = 12'hC3A;
        #1 chk(busy == 1'b0, "R6 collision busy cleared", busy, 0);
        chk(start == 1'b0, "R6 collision edge ignored", start, 0);
        tick(); #1 chk(start == 1'b0 && busy == 1'b0, "R6 edge consumed", {start, busy}, 0);
        do_read(1'b1, 1'b0, "R8 read after collision");

        // R12: stand-alone low pulse
        ce = 1'b1; cs_n = 1'b0; a0 = 1'b0; word_mode = 1'b1; rc = 1'b1;
        #1 chk(oe == 12'hFFF && data == exp_res, "R12 enabled while rc high", oe, 12'hFFF);
        tick(); rc = 1'b0;
        #1 chk(oe == 12'h000, "R12 off on falling rc", oe, 0);
        tick(); rc = 1'b1;
        #1 chk(start == 1'b1, "R12 falling rc starts", start, 1);
        chk(oe == 12'h000, "R12 off while busy with rc high", oe, 0);
        repeat (3) tick();
        done = 1'b1; result = 12'h5A3;
        tick(); done = 1'b0; exp_res = 12'h5A3;
        #1 chk(busy == 1'b0, "R12 busy cleared", busy, 0);
        chk(oe == 12'hFFF && data == 12'h5A3, "R12 valid after completion", data, 12'h5A3);

        // random conversions and reads
        for (int n = 0; n < 25; n++) begin
            convert(1'($urandom_range(0, 1)), 12'($urandom), $urandom_range(1, 6));
            for (int k = 0; k < 3; k++) begin
                tick();
                do_read(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8/R9/R10 random read");
            end
        end

        idle(); tick();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule